// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is a bank of 32 general-purpose pins behind a small word-addressed register port. Software writes an output value register and a per-pin direction register; the output value drives `pad_out` and the direction drives `pad_oe`. The pad levels come back through a two-stage synchronizer and can be read from a read-only level register. Reading the output value register returns what was written, whatever the pad is doing.

Every pin can raise an interrupt. A 2-bit trigger code per pin selects one of four conditions: low level, high level, rising edge or falling edge. A separate per-pin bit selects "any edge" and overrides that code. Each detected condition sets a sticky bit in a status register. Software clears a status bit by writing 1 to it. A status bit that is also enabled in the mask register is pending. Two interrupt lines leave the block: one covers pins 0 to 15 and the other covers pins 16 to 31.

The bus is a single-cycle interface. A write is taken on the clock edge at which `bus_sel` and `bus_wr` are high. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_port_irq`

## Requirements
- R1: A write to byte offset 0x00 loads the output value register, and `pad_out` shows it from the next cycle. A read of 0x00 returns the written value, independent of `pad_in`.
- R2: A write to offset 0x04 loads the direction register. `pad_oe[n]` is 1 exactly when direction bit n is 1 (1 = output), and a read of 0x04 returns it.
- R3: A read of offset 0x08 returns `pad_in` delayed by two clock edges (two-flop synchronizer). It still shows the old level after one edge and the new level after two.
- R4: Trigger code 2'b00 (low level) sets the pin's status bit on every cycle the synchronized level is 0. A clear therefore has no lasting effect while the level stays low.
- R5: Trigger code 2'b01 (high level) sets the status bit on every cycle the synchronized level is 1.
- R6: Trigger code 2'b10 sets the status bit on a synchronized 0-to-1 change. Code 2'b11 sets it on a 1-to-0 change. A steady level sets nothing.
- R7: Pins 0 to 15 take their trigger code from offset 0x0C and pins 16 to 31 from offset 0x10. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)] of its register.
- R8: When bit n of the any-edge register (offset 0x1C) is 1, pin n sets its status bit on both edges, and its trigger code is ignored (no level trigger, no single-edge filtering).
- R9: The status register (offset 0x18) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: When a detected condition and a write-1-to-clear reach the same status bit on the same clock edge, the bit ends up set.
- R11: Bit n is pending when status bit n and mask bit n (offset 0x14) are both 1. `irq_lo` is the OR of pending bits 0 to 15 and `irq_hi` is the OR of pending bits 16 to 31. A masked bit drives neither line.
- R12: While reset is asserted, every register reads 0, `pad_out`, `pad_oe`, `irq_lo` and `irq_hi` are 0, and all pins are inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when not reading |
| pad_in | input | PINS | Asynchronous pad levels |
| pad_out | output | PINS | Output value to the pad drivers |
| pad_oe | output | PINS | Output enable per pin |
| irq_lo | output | 1 | Pending interrupt among pins 0 to 15 |
| irq_hi | output | 1 | Pending interrupt among pins 16 to 31 |

## Verification
The hardest case to reach from the ports is a detected edge and a clear write that land on the same status bit on the same clock edge. The bench changes the pad at a falling clock edge and waits two rising edges for the synchronizer. It then issues the clear so that it is taken on the third edge, when the edge event is present. It repeats the sequence one cycle later to show that the clear does take effect once the event has passed. The trigger sweep runs all five conditions on every one of the 32 pins. Each pin is put through a steady level, a rise, a clear and a fall, so a misplaced code field or a crossed half shows up on a specific pin and line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word index of each register (byte address bits [4:2])
  typedef enum logic [2:0] {
    RI_DATA   = 3'd0,
    RI_DIR    = 3'd1,
    RI_LEVEL  = 3'd2,
    RI_CFG_LO = 3'd3,
    RI_CFG_HI = 3'd4,
    RI_MASK   = 3'd5,
    RI_STAT   = 3'd6,
    RI_ANYEDG = 3'd7
  } reg_idx_e;

  // Per-pin trigger condition codes
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // Extract the 2-bit trigger code for one pin; the lower half of the
  // pins lives in cfg_lo, the upper half in cfg_hi.
  function automatic trig_e pin_code(input logic [31:0] cfg_lo,
                                     input logic [31:0] cfg_hi,
                                     input int unsigned pin,
                                     input int unsigned half);
    logic [31:0] src;
    int unsigned slot;
    src  = (pin < half) ? cfg_lo : cfg_hi;
    slot = (pin < half) ? pin : pin - half;
    return trig_e'(src[2*slot +: 2]);
  endfunction

  // Decide whether a pin reports a condition this cycle.
  function automatic logic pin_event(input trig_e code,
                                     input logic  any_edge,
                                     input logic  cur,
                                     input logic  prv);
    if (any_edge) return cur ^ prv;
    case (code)
      TRIG_LOW:  return ~cur;
      TRIG_HIGH: return cur;
      TRIG_RISE: return cur & ~prv;
      default:   return ~cur & prv;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5,
  localparam int HALF  = PINS / 2,
  localparam int CFG_W = 2 * HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pad_lvl,
  input  logic [PINS-1:0]   stat_q,
  output logic [PINS-1:0]   data_q,
  output logic [PINS-1:0]   dir_q,
  output logic [CFG_W-1:0]  cfg_lo_q,
  output logic [CFG_W-1:0]  cfg_hi_q,
  output logic [PINS-1:0]   mask_q,
  output logic [PINS-1:0]   anyedg_q,
  output logic [PINS-1:0]   stat_clr
);
  reg_idx_e idx;
  logic     wr_en;
  logic     unused_addr_bits;

  assign idx              = reg_idx_e'(bus_addr[4:2]);
  assign wr_en            = bus_sel & bus_wr;
  assign unused_addr_bits = ^{bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      anyedg_q <= '0;
    end else if (wr_en) begin
      case (idx)
        RI_DATA:   data_q   <= bus_wdata[PINS-1:0];
        RI_DIR:    dir_q    <= bus_wdata[PINS-1:0];
        RI_CFG_LO: cfg_lo_q <= bus_wdata[CFG_W-1:0];
        RI_CFG_HI: cfg_hi_q <= bus_wdata[CFG_W-1:0];
        RI_MASK:   mask_q   <= bus_wdata[PINS-1:0];
        RI_ANYEDG: anyedg_q <= bus_wdata[PINS-1:0];
        default:   ;
      endcase
    end
  end

  // Write-one-to-clear request towards the status logic
  assign stat_clr = (wr_en && idx == RI_STAT) ? bus_wdata[PINS-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (idx)
        RI_DATA:   bus_rdata = 32'(data_q);
        RI_DIR:    bus_rdata = 32'(dir_q);
        RI_LEVEL:  bus_rdata = 32'(pad_lvl);
        RI_CFG_LO: bus_rdata = 32'(cfg_lo_q);
        RI_CFG_HI: bus_rdata = 32'(cfg_hi_q);
        RI_MASK:   bus_rdata = 32'(mask_q);
        RI_STAT:   bus_rdata = 32'(stat_q);
        default:   bus_rdata = 32'(anyedg_q);
      endcase
    end
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 32,
  localparam int HALF  = PINS / 2,
  localparam int CFG_W = 2 * HALF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  pad_lvl,
  input  logic [CFG_W-1:0] cfg_lo,
  input  logic [CFG_W-1:0] cfg_hi,
  input  logic [PINS-1:0]  anyedg,
  input  logic [PINS-1:0]  stat_clr,
  output logic [PINS-1:0]  prev_lvl,
  output logic [PINS-1:0]  evt,
  output logic [PINS-1:0]  stat_q
);
  logic [31:0] cfg_lo_w;
  logic [31:0] cfg_hi_w;

  assign cfg_lo_w = 32'(cfg_lo);
  assign cfg_hi_w = 32'(cfg_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else        prev_lvl <= pad_lvl;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign evt[p] = pin_event(pin_code(cfg_lo_w, cfg_hi_w, p, HALF),
                              anyedg[p], pad_lvl[p], prev_lvl[p]);

    // event has priority over a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q[p] <= 1'b0;
      else if (evt[p])   stat_q[p] <= 1'b1;
      else if (stat_clr[p]) stat_q[p] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF  = PINS / 2;
  localparam int CFG_W = 2 * HALF;

  logic [PINS-1:0]  pad_lvl;
  logic [PINS-1:0]  prev_lvl;
  logic [PINS-1:0]  evt;
  logic [PINS-1:0]  stat_q;
  logic [PINS-1:0]  stat_clr;
  logic [PINS-1:0]  mask_q;
  logic [PINS-1:0]  anyedg_q;
  logic [PINS-1:0]  data_q;
  logic [PINS-1:0]  dir_q;
  logic [CFG_W-1:0] cfg_lo_q;
  logic [CFG_W-1:0] cfg_hi_q;
  logic [PINS-1:0]  pending;

  gpio_sync #(.W(PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_lvl)
  );

  gpio_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_lvl   (pad_lvl),
    .stat_q    (stat_q),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .cfg_lo_q  (cfg_lo_q),
    .cfg_hi_q  (cfg_hi_q),
    .mask_q    (mask_q),
    .anyedg_q  (anyedg_q),
    .stat_clr  (stat_clr)
  );

  gpio_detect #(.PINS(PINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_lvl  (pad_lvl),
    .cfg_lo   (cfg_lo_q),
    .cfg_hi   (cfg_hi_q),
    .anyedg   (anyedg_q),
    .stat_clr (stat_clr),
    .prev_lvl (prev_lvl),
    .evt      (evt),
    .stat_q   (stat_q)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign pending = stat_q & mask_q;
  assign irq_lo  = |pending[HALF-1:0];
  assign irq_hi  = |pending[PINS-1:HALF];
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5,
  localparam int HALF  = PINS / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_lvl,
  input logic [PINS-1:0]   prev_lvl,
  input logic [PINS-1:0]   evt,
  input logic [PINS-1:0]   stat_q,
  input logic [PINS-1:0]   stat_clr,
  input logic [PINS-1:0]   mask_q,
  input logic [PINS-1:0]   anyedg_q,
  input logic              irq_lo,
  input logic              irq_hi
);
  assert_data_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[4:2] == 3'd0) |=> pad_out == $past(bus_wdata[PINS-1:0]));

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> pad_lvl == $past(pad_in, 2));

  assert_anyedge_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & anyedg_q & ~(pad_lvl ^ prev_lvl)) == '0);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q & $past(stat_clr) & ~$past(evt)) == '0);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q & $past(stat_q & ~stat_clr)) == $past(stat_q & ~stat_clr));

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_q & $past(evt)) == $past(evt));

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |-> (!irq_lo && !irq_hi));

  assert_lo_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (stat_q[HALF-1:0] & mask_q[HALF-1:0]) != '0);

  assert_hi_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (stat_q[PINS-1:HALF] & mask_q[PINS-1:HALF]) != '0);
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_lvl   (pad_lvl),
  .prev_lvl  (prev_lvl),
  .evt       (evt),
  .stat_q    (stat_q),
  .stat_clr  (stat_clr),
  .mask_q    (mask_q),
  .anyedg_q  (anyedg_q),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi)
);

// File: tb/test_gpio_port_irq.sv
`timescale 1ns/1ps
module test_gpio_port_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq_lo;
  logic        irq_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_irq i_gpio_port_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic expect_bit(input int step, input int m);
    case (step)
      0:       return m == 0;   // steady low after clear
      1:       return m != 3;   // after a rise (sticky)
      2:       return m == 1;   // clear while high
      default: return m != 2;   // after a fall
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R4 R7";
      1: return "R5 R7";
      2: return "R6 R7 rise";
      3: return "R6 R7 fall";
      default: return "R8";
    endcase
  endfunction

  task automatic probe(input int p, input int m, input int step);
    logic [31:0] st;
    logic e;
    bus_read(5'h18, st);
    e = expect_bit(step, m);
    check(mode_tag(m), {31'd0, st[p]}, {31'd0, e});
    check("R11 irq_lo", {31'd0, irq_lo}, {31'd0, e && p < 16});
    check("R11 irq_hi", {31'd0, irq_hi}, {31'd0, e && p >= 16});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    // R12: reset state, read while reset is held
    wait_cyc(2);
    for (int r = 0; r < 8; r++) begin
      bus_read(5'(r * 4), rd);
      check("R12 register", rd, 32'h0);
    end
    check("R12 pad_out", pad_out, 32'h0);
    check("R12 pad_oe", pad_oe, 32'h0);
    check("R12 irq", {30'd0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);

    // R1 / R2: output value and direction patterns
    for (int i = 0; i < 8; i++) begin
      logic [31:0] dv, ov;
      dv = (32'h1 << (i * 4)) ^ (32'h9E37_79B9 * 32'(i + 1));
      ov = ~dv ^ (32'h0F0F_0F0F << i);
      @(negedge clk) pad_in = ~dv;
      bus_write(5'h00, dv);
      bus_write(5'h04, ov);
      check("R1 pad_out", pad_out, dv);
      check("R2 pad_oe", pad_oe, ov);
      bus_read(5'h00, rd); check("R1 readback ignores pad", rd, dv);
      bus_read(5'h04, rd); check("R2 readback", rd, ov);
    end
    bus_write(5'h04, 32'h0);

    // R3: two-edge synchronizer latency
    @(negedge clk) pad_in = 32'h0;
    wait_cyc(3);
    @(negedge clk) pad_in = 32'hC3A5_5A3C;
    bus_read(5'h08, rd); check("R3 one edge old", rd, 32'h0);
    bus_read(5'h08, rd); check("R3 two edges new", rd, 32'hC3A5_5A3C);

    // R4-R9, R11: every pin, every trigger condition
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic [31:0] cfgv;
        @(negedge clk) pad_in = 32'h0;
        wait_cyc(4);
        cfgv = (m == 4) ? 32'h0 : (32'(m) << (2 * (p % 16)));
        bus_write(5'h0C, p < 16 ? cfgv : 32'h0);
        bus_write(5'h10, p < 16 ? 32'h0 : cfgv);
        bus_write(5'h1C, m == 4 ? (32'h1 << p) : 32'h0);
        bus_write(5'h14, 32'h1 << p);
        bus_write(5'h18, 32'hFFFF_FFFF);
        probe(p, m, 0);
        @(negedge clk) pad_in = 32'h1 << p;
        wait_cyc(4);
        probe(p, m, 1);
        bus_write(5'h18, 32'h0);          // R9: writing 0 changes nothing
        probe(p, m, 1);
        bus_write(5'h18, 32'h1 << p);     // R9: write 1 clears
        probe(p, m, 2);
        @(negedge clk) pad_in = 32'h0;
        wait_cyc(4);
        probe(p, m, 3);
      end
    end

    // R11: masked status drives neither line
    bus_write(5'h0C, 32'h0);
    bus_write(5'h10, 32'h0);
    bus_write(5'h1C, 32'h0);
    bus_write(5'h14, 32'h0);
    bus_read(5'h18, rd);
    check("R11 status set under low level", rd, 32'hFFFF_FFFF);
    check("R11 masked quiet", {30'd0, irq_hi, irq_lo}, 32'h0);
    bus_write(5'h14, 32'h0001_0000);
    @(negedge clk);
    check("R11 upper only", {30'd0, irq_hi, irq_lo}, 32'h2);

    // R10: rising edge and clear on the same edge of pin 5
    bus_write(5'h14, 32'h0);
    bus_write(5'h0C, 32'(2) << 10);
    @(negedge clk) pad_in = 32'h0;
    wait_cyc(4);
    bus_write(5'h18, 32'hFFFF_FFFF);
    @(negedge clk) pad_in = 32'h20;
    @(posedge clk); @(posedge clk);
    bus_write(5'h18, 32'h20);
    bus_read(5'h18, rd);
    check("R10 event beats clear", {31'd0, rd[5]}, 32'h1);
    // same clear one cycle after the event: it takes effect
    @(negedge clk) pad_in = 32'h0;
    wait_cyc(4);
    bus_write(5'h18, 32'h20);
    @(negedge clk) pad_in = 32'h20;
    @(posedge clk); @(posedge clk); @(posedge clk);
    bus_write(5'h18, 32'h20);
    bus_read(5'h18, rd);
    check("R10 later clear wins", {31'd0, rd[5]}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule